// File: doc/BRIEF.md
# Power-Sourcing Port Command Sequencer

This block is the control core of one power-sourcing Ethernet port. Software drives it through a small register window: an operating-mode field, three command bits (run detection, run classification, switch power on), a status word and a detection-end event flag. The sequencer walks the port through idle, detection, classification and powered states. It fires one-cycle start strobes at external detection and classification engines and takes back their done pulses and 3-bit result codes. It also drives the enable of the port power switch.

How a command bit is read depends on the mode. In the two automatic modes the detect and classify bits are standing configuration. In manual mode they are pushbuttons that clear themselves. In shutdown every command is refused. A midspan port holds off for a programmable interval (2.0 s by default) after each failed detection. The legacy high-capacitance enable is taken from an input pin while reset is held.

Register map:
- Address 0 is configuration. Bits [1:0] hold the mode: 00 shutdown, 01 manual, 10 automatic, 11 midspan. Bit [2] is the legacy enable.
- Address 1 is the command register. Bit [0] is detect and bit [1] is classify. Bit [2] is power-on; it acts on write only and always reads as 0.
- Address 2 returns the detection-end flag in bit [0] and does not clear it.
- Address 3 returns the same flag in bit [0] and clears it when read.
- Address 4 is status. Bits [2:0] hold the last detection code and bits [5:3] the last classification code. Bits [7:6] hold the port state: 00 idle, 01 detecting, 10 classifying, 11 powered.

A detection code of 100 means a valid signature. Every other detection code counts as a failure.

Top module: `poe_port_seq`

## Requirements
- R1: A write of 1 to command bit [2], in any mode other than shutdown, moves the port to the powered state on that clock edge and raises `pwr_en`, even if a detection or classification is in progress.
- R2: With detect and classify both set, the detection start strobe comes first. Classification starts only when the detection result is 100. Two start strobes are never active together.
- R3: While the port is powered, writes to command bits [1:0] leave those bits unchanged and start no operation.
- R4: A configuration write that changes the mode to manual from any other mode clears command bits [1:0].
- R5: In manual mode, a 1 written to bit [0] or bit [1] runs exactly one operation of that kind. The bit reads back 0 once the operation ends, or once a failed detection cancels a pending classification.
- R6: Mode 00 turns `pwr_en` off in the cycle after the write and returns the port to idle. It clears both result codes and the detection-end flag, and it ignores all command writes. The register window stays accessible.
- R7: Each completed detection sets the detection-end flag and stores the 3-bit result in status bits [2:0]. A read at address 3 clears the flag. A read at address 2 does not.
- R8: In midspan mode, the next detection start comes no sooner than the backoff interval after a failed detection. The first detection in midspan mode starts without delay.
- R9: While reset is held, configuration bit [2] follows the `legacy_pin` input. After reset it keeps the latched value until a configuration write changes it.
- R10: `pwr_en` is low whenever a detection is started and for the rest of that detection.
- R11: If a detection completes in the same cycle as a clear-on-read access, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_pin | input | 1 | Legacy capacitance enable sampled during reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Read strobe; qualifies the clear-on-read side effect |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational from `rd_addr` |
| det_start | output | 1 | One-cycle start for the detection engine |
| det_done | input | 1 | Detection engine finished |
| det_result | input | 3 | Detection result code, valid with `det_done` |
| cls_start | output | 1 | One-cycle start for the classification engine |
| cls_done | input | 1 | Classification engine finished |
| cls_result | input | 3 | Classification result code, valid with `cls_done` |
| pwr_en | output | 1 | Port power switch enable |

## Verification
A wrong internal state shows up at the engine strobes or the status word within one or two cycles.

- A stale command bit appears as an extra start strobe, which the scoreboard flags as an item it did not expect.
- A wrong result code or state appears in the status word on the next read.
- A power-on that arrives late, or a shutdown that leaves power on, is seen on `pwr_en` in the cycle right after the write.
- A backoff counter that is too short or is not reset changes the spacing between two detection starts by thousands of cycles. That spacing is measured against a window of a few cycles.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_MANUAL  = 2'b01,
        MODE_AUTO    = 2'b10,
        MODE_MIDSPAN = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_DETECT   = 2'b01,
        ST_CLASSIFY = 2'b10,
        ST_POWERED  = 2'b11
    } port_st_e;

    localparam logic [ADDR_W-1:0] A_CFG      = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMD      = 3'd1;
    localparam logic [ADDR_W-1:0] A_EVT_PEEK = 3'd2;
    localparam logic [ADDR_W-1:0] A_EVT_COR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT     = 3'd4;

    localparam logic [CODE_W-1:0] DET_OK = 3'b100;

    // Per-edge events raised by the state machine toward the register file
    typedef struct packed {
        logic det_end_set;
        logic cls_end_set;
        logic clr_det;
        logic clr_cls;
    } fsm_evt_t;

    function automatic logic [DATA_W-1:0] stat_word(port_st_e st,
                                                    logic [CODE_W-1:0] dc,
                                                    logic [CODE_W-1:0] cc);
        return DATA_W'({st, cc, dc});
    endfunction

endpackage

// File: rtl/poe_backoff_timer.sv
module poe_backoff_timer #(
    parameter int CLK_FREQ_HZ = 25_000_000,
    parameter int BACKOFF_MS  = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    output logic busy
);
    localparam int PRESC = (CLK_FREQ_HZ / 1000 < 1) ? 1 : CLK_FREQ_HZ / 1000;
    localparam int MS    = (BACKOFF_MS < 1) ? 1 : BACKOFF_MS;
    localparam int PW    = $clog2(PRESC + 1);
    localparam int MW    = $clog2(MS + 1);

    logic          tick;
    logic [MW-1:0] ms_q;

    generate
        if (PRESC == 1) begin : g_nopre
            assign tick = 1'b1;
        end else begin : g_pre
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst || clr || start || !busy)
                    pre_q <= '0;
                else if (pre_q == PW'(PRESC - 1))
                    pre_q <= '0;
                else
                    pre_q <= pre_q + 1'b1;
            end
            assign tick = busy && (pre_q == PW'(PRESC - 1));
        end
    endgenerate

    // busy stays high for exactly PRESC*MS cycles after start
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy <= 1'b0;
            ms_q <= '0;
        end else if (start) begin
            busy <= 1'b1;
            ms_q <= '0;
        end else if (busy && tick) begin
            if (ms_q == MW'(MS - 1))
                busy <= 1'b0;
            else
                ms_q <= ms_q + 1'b1;
        end
    end

endmodule

// File: rtl/poe_cmd_regs.sv
module poe_cmd_regs
    import poe_seq_pkg::*;
#(
    parameter op_mode_e RESET_MODE = MODE_AUTO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              legacy_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  port_st_e          st,
    input  logic [CODE_W-1:0] det_code,
    input  logic [CODE_W-1:0] cls_code,
    input  fsm_evt_t          evt,
    output op_mode_e          mode,
    output logic              hicap,
    output logic              det_en,
    output logic              cls_en,
    output logic              pwr_req,
    output logic              det_end,
    output logic [DATA_W-1:0] rd_data
);
    logic     wr_cfg, wr_cmd, cmd_ok, cor_hit;
    op_mode_e new_mode;

    assign wr_cfg   = wr_en && (wr_addr == A_CFG);
    assign wr_cmd   = wr_en && (wr_addr == A_CMD);
    assign new_mode = op_mode_e'(wr_data[1:0]);
    assign cmd_ok   = (mode != MODE_OFF) && (st != ST_POWERED);
    assign cor_hit  = rd_en && (rd_addr == A_EVT_COR);
    assign pwr_req  = wr_cmd && wr_data[2] && (mode != MODE_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= RESET_MODE;
            hicap  <= legacy_pin;
            det_en <= 1'b0;
            cls_en <= 1'b0;
        end else begin
            if (evt.clr_det) det_en <= 1'b0;
            if (evt.clr_cls) cls_en <= 1'b0;
            if (wr_cmd && cmd_ok) begin
                det_en <= wr_data[0];
                cls_en <= wr_data[1];
            end
            if (wr_cfg) begin
                mode  <= new_mode;
                hicap <= wr_data[2];
                if (new_mode == MODE_MANUAL && mode != MODE_MANUAL) begin
                    det_en <= 1'b0;
                    cls_en <= 1'b0;
                end
            end
        end
    end

    // Event flag: a new set beats a same-cycle clear-on-read
    always_ff @(posedge clk) begin
        if (rst || mode == MODE_OFF)
            det_end <= 1'b0;
        else if (evt.det_end_set)
            det_end <= 1'b1;
        else if (cor_hit)
            det_end <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CFG:      rd_data = DATA_W'({hicap, mode});
            A_CMD:      rd_data = DATA_W'({cls_en, det_en});
            A_EVT_PEEK: rd_data = DATA_W'(det_end);
            A_EVT_COR:  rd_data = DATA_W'(det_end);
            A_STAT:     rd_data = stat_word(st, det_code, cls_code);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/poe_port_fsm.sv
module poe_port_fsm
    import poe_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_mode_e          mode,
    input  logic              det_en,
    input  logic              cls_en,
    input  logic              pwr_req,
    input  logic              backoff_busy,
    input  logic              det_done,
    input  logic [CODE_W-1:0] det_result,
    input  logic              cls_done,
    input  logic [CODE_W-1:0] cls_result,
    output port_st_e          st,
    output logic              det_start,
    output logic              cls_start,
    output logic [CODE_W-1:0] det_code,
    output logic [CODE_W-1:0] cls_code,
    output fsm_evt_t          evt,
    output logic              backoff_start
);
    port_st_e st_n;
    logic     dstart_n, cstart_n, manual;

    assign manual = (mode == MODE_MANUAL);

    always_comb begin
        st_n          = st;
        evt           = '0;
        dstart_n      = 1'b0;
        cstart_n      = 1'b0;
        backoff_start = 1'b0;
        if (mode == MODE_OFF) begin
            st_n = ST_IDLE;
        end else if (pwr_req) begin
            st_n = ST_POWERED;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (det_en && !backoff_busy) begin
                        st_n     = ST_DETECT;
                        dstart_n = 1'b1;
                    end else if (cls_en && !det_en) begin
                        st_n     = ST_CLASSIFY;
                        cstart_n = 1'b1;
                    end
                end
                ST_DETECT: begin
                    if (det_done) begin
                        evt.det_end_set = 1'b1;
                        evt.clr_det     = manual;
                        if (det_result == DET_OK && cls_en) begin
                            st_n     = ST_CLASSIFY;
                            cstart_n = 1'b1;
                        end else begin
                            st_n          = ST_IDLE;
                            evt.clr_cls   = manual;
                            backoff_start = (mode == MODE_MIDSPAN) &&
                                            (det_result != DET_OK);
                        end
                    end
                end
                ST_CLASSIFY: begin
                    if (cls_done) begin
                        evt.cls_end_set = 1'b1;
                        evt.clr_cls     = manual;
                        st_n            = ST_IDLE;
                    end
                end
                default: st_n = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            det_start <= 1'b0;
            cls_start <= 1'b0;
            det_code  <= '0;
            cls_code  <= '0;
        end else begin
            st        <= st_n;
            det_start <= dstart_n;
            cls_start <= cstart_n;
            if (mode == MODE_OFF) begin
                det_code <= '0;
                cls_code <= '0;
            end else begin
                if (evt.det_end_set) det_code <= det_result;
                if (evt.cls_end_set) cls_code <= cls_result;
            end
        end
    end

endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
    import poe_seq_pkg::*;
#(
    parameter int       CLK_FREQ_HZ = 25_000_000,
    parameter int       BACKOFF_MS  = 2000,
    parameter op_mode_e RESET_MODE  = MODE_AUTO
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       legacy_pin,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       det_start,
    input  logic       det_done,
    input  logic [2:0] det_result,
    output logic       cls_start,
    input  logic       cls_done,
    input  logic [2:0] cls_result,
    output logic       pwr_en
);
    op_mode_e          mode;
    port_st_e          st;
    fsm_evt_t          evt;
    logic              hicap, det_en, cls_en, pwr_req, det_end;
    logic              backoff_busy, backoff_start;
    logic [CODE_W-1:0] det_code, cls_code;

    poe_cmd_regs #(.RESET_MODE(RESET_MODE)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .legacy_pin (legacy_pin),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .st         (st),
        .det_code   (det_code),
        .cls_code   (cls_code),
        .evt        (evt),
        .mode       (mode),
        .hicap      (hicap),
        .det_en     (det_en),
        .cls_en     (cls_en),
        .pwr_req    (pwr_req),
        .det_end    (det_end),
        .rd_data    (rd_data)
    );

    poe_port_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .mode          (mode),
        .det_en        (det_en),
        .cls_en        (cls_en),
        .pwr_req       (pwr_req),
        .backoff_busy  (backoff_busy),
        .det_done      (det_done),
        .det_result    (det_result),
        .cls_done      (cls_done),
        .cls_result    (cls_result),
        .st            (st),
        .det_start     (det_start),
        .cls_start     (cls_start),
        .det_code      (det_code),
        .cls_code      (cls_code),
        .evt           (evt),
        .backoff_start (backoff_start)
    );

    poe_backoff_timer #(
        .CLK_FREQ_HZ (CLK_FREQ_HZ),
        .BACKOFF_MS  (BACKOFF_MS)
    ) u_backoff (
        .clk   (clk),
        .rst   (rst),
        .clr   (mode != MODE_MIDSPAN),
        .start (backoff_start),
        .busy  (backoff_busy)
    );

    // Shutdown cuts the switch combinationally, ahead of the state update
    assign pwr_en = (st == ST_POWERED) && (mode != MODE_OFF);

endmodule

// File: rtl/poe_port_seq_chk.sv
module poe_port_seq_chk
    import poe_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input op_mode_e   mode,
    input port_st_e   st,
    input logic       det_en,
    input logic       cls_en,
    input logic       pwr_req,
    input logic       pwr_en,
    input logic       det_start,
    input logic       cls_start,
    input logic       backoff_busy,
    input logic       evt_det_set,
    input logic       det_end
);

    assert_pwr_on_wins_R1: assert property (@(posedge clk) disable iff (rst)
        pwr_req |=> (st == ST_POWERED) && pwr_en);

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({det_start, cls_start}));

    assert_powered_ignores_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_POWERED && wr_en && wr_addr == A_CMD)
        |=> ($stable(det_en) && $stable(cls_en)));

    assert_manual_entry_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_CFG && wr_data[1:0] == MODE_MANUAL && mode != MODE_MANUAL)
        |=> (!det_en && !cls_en));

    assert_shutdown_idles_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |=> (st == ST_IDLE));

    assert_event_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        evt_det_set |=> det_end);

    assert_backoff_blocks_detect_R8: assert property (@(posedge clk) disable iff (rst)
        backoff_busy |-> !det_start);

    assert_switch_off_in_detect_R10: assert property (@(posedge clk) disable iff (rst)
        (det_start || st == ST_DETECT) |-> !pwr_en);

endmodule

bind poe_port_seq poe_port_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .mode         (mode),
    .st           (st),
    .det_en       (det_en),
    .cls_en       (cls_en),
    .pwr_req      (pwr_req),
    .pwr_en       (pwr_en),
    .det_start    (det_start),
    .cls_start    (cls_start),
    .backoff_busy (backoff_busy),
    .evt_det_set  (evt.det_end_set),
    .det_end      (det_end)
);

// File: tb/poe_port_seq_tb.sv
module poe_port_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FREQ       = 10_000;
    localparam int BMS        = 2000;
    localparam int BK         = (FREQ / 1000) * BMS;
    localparam int RESP_DLY   = 3;

    logic       clk = 1'b0;
    logic       rst, legacy_pin, wr_en, rd_en;
    logic [2:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic       det_start, det_done, cls_start, cls_done, pwr_en;
    logic [2:0] det_result, cls_result;

    always #(CLK_PERIOD / 2) clk = ~clk;

    poe_port_seq #(.CLK_FREQ_HZ(FREQ), .BACKOFF_MS(BMS)) u_dut (
        .clk(clk), .rst(rst), .legacy_pin(legacy_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .det_start(det_start), .det_done(det_done), .det_result(det_result),
        .cls_start(cls_start), .cls_done(cls_done), .cls_result(cls_result),
        .pwr_en(pwr_en)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   exp_q[$];   // 0 = detection start expected, 1 = classification start
    int   ds_cyc[$];
    bit   auto_resp = 1'b1;
    bit   man_tog = 1'b0;
    logic [2:0] man_code = 3'b100;
    logic [2:0] next_det = 3'b100;
    logic [2:0] next_cls = 3'b010;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic cor(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Engine models: one process owns the done/result pins
    initial begin
        bit man_seen;
        int dcnt, ccnt;
        man_seen = 1'b0; dcnt = 0; ccnt = 0;
        det_done = 1'b0; cls_done = 1'b0; det_result = '0; cls_result = '0;
        forever begin
            @(negedge clk);
            det_done = 1'b0;
            cls_done = 1'b0;
            if (man_tog != man_seen) begin
                man_seen   = man_tog;
                det_done   = 1'b1;
                det_result = man_code;
            end else if (dcnt == 1) begin
                det_done   = 1'b1;
                det_result = next_det;
                dcnt       = 0;
            end else if (dcnt > 1) begin
                dcnt--;
            end
            if (ccnt == 1) begin
                cls_done   = 1'b1;
                cls_result = next_cls;
                ccnt       = 0;
            end else if (ccnt > 1) begin
                ccnt--;
            end
            if (det_start && auto_resp) dcnt = RESP_DLY;
            if (cls_start && auto_resp) ccnt = RESP_DLY;
        end
    end

    // Scoreboard monitor: every start strobe must match the next expected item
    initial begin
        forever begin
            @(negedge clk);
            if (det_start) begin
                ds_cyc.push_back(cyc);
                chk(!pwr_en, "R10 switch on at detection start", int'(pwr_en), 0);
                if (exp_q.size() == 0)
                    chk(1'b0, "R2 unexpected detection start", 0, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(e == 0, "R2 strobe order (detect)", 0, e);
                end
            end
            if (cls_start) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R2 unexpected classification start", 1, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(e == 1, "R2 strobe order (classify)", 1, e);
                end
            end
        end
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, a0;
        int w, gap;
        rst = 1'b1; legacy_pin = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        legacy_pin = 1'b0;

        // Reset state, legacy latch (R9)
        chk(pwr_en == 1'b0, "R6 reset pwr_en", int'(pwr_en), 0);
        peek(3'd0, v); chk(v == 8'h06, "R9 cfg after reset", v, 8'h06);
        peek(3'd4, v); chk(v == 8'h00, "R7 status after reset", v, 8'h00);
        peek(3'd2, v); chk(v == 8'h00, "R7 flag after reset", v, 8'h00);
        wr(3'd0, 8'h02);
        peek(3'd0, v); chk(v == 8'h02, "R9 software overwrite", v, 8'h02);

        // Manual single detection (R5, R7)
        wr(3'd0, 8'h01);
        exp_q.push_back(0);
        wr(3'd1, 8'h01);
        repeat (20) @(negedge clk);
        peek(3'd1, v); chk(v == 8'h00, "R5 detect bit self-clear", v, 8'h00);
        peek(3'd2, v); chk(v == 8'h01, "R7 flag set", v, 8'h01);
        peek(3'd2, v); chk(v == 8'h01, "R7 peek does not clear", v, 8'h01);
        peek(3'd4, v); chk(v == 8'h04, "R7 status code", v, 8'h04);
        cor(3'd3, v);  chk(v == 8'h01, "R7 clear-on-read returns flag", v, 8'h01);
        peek(3'd2, v); chk(v == 8'h00, "R7 flag cleared", v, 8'h00);

        // Both bits: detect then classify (R2, R5)
        exp_q.push_back(0); exp_q.push_back(1);
        wr(3'd1, 8'h03);
        repeat (20) @(negedge clk);
        peek(3'd4, v); chk(v == 8'h14, "R2 detect+classify status", v, 8'h14);
        peek(3'd1, v); chk(v == 8'h00, "R5 both bits self-clear", v, 8'h00);

        // Failed detection cancels pending classify (R2, R5)
        next_det = 3'b001;
        exp_q.push_back(0);
        wr(3'd1, 8'h03);
        repeat (20) @(negedge clk);
        peek(3'd4, v); chk(v == 8'h11, "R2 no classify after fail", v, 8'h11);
        peek(3'd1, v); chk(v == 8'h00, "R5 bits clear after fail", v, 8'h00);
        next_det = 3'b100;

        // Power-on aborts detection (R1)
        auto_resp = 1'b0;
        exp_q.push_back(0);
        wr(3'd1, 8'h01);
        repeat (3) @(negedge clk);
        peek(3'd4, v); chk(v[7:6] == 2'b01, "R1 detecting before power-on", v[7:6], 2'b01);
        wr(3'd1, 8'h04);
        chk(pwr_en == 1'b1, "R1 pwr_en immediate", int'(pwr_en), 1);
        peek(3'd4, v); chk(v[7:6] == 2'b11, "R1 powered state", v[7:6], 2'b11);
        auto_resp = 1'b1;

        // Powered ignores detect/classify (R3)
        peek(3'd1, a0);
        wr(3'd1, 8'h02);
        repeat (10) @(negedge clk);
        peek(3'd1, v); chk(v == a0, "R3 command bits unchanged", v, a0);
        peek(3'd4, v); chk(v[7:6] == 2'b11, "R3 still powered", v[7:6], 2'b11);

        // Shutdown (R6)
        wr(3'd0, 8'h00);
        chk(pwr_en == 1'b0, "R6 power off at once", int'(pwr_en), 0);
        peek(3'd4, v); chk(v == 8'h00, "R6 status cleared", v, 8'h00);
        peek(3'd2, v); chk(v == 8'h00, "R6 event cleared", v, 8'h00);
        wr(3'd1, 8'h04);
        chk(pwr_en == 1'b0, "R6 power-on ignored", int'(pwr_en), 0);
        wr(3'd1, 8'h01);
        repeat (10) @(negedge clk);
        peek(3'd4, v); chk(v == 8'h00, "R6 detect ignored", v, 8'h00);

        // Enter manual clears bits (R4); set wins over clear (R11)
        wr(3'd0, 8'h01);
        peek(3'd1, v); chk(v == 8'h00, "R4 manual entry clears bits", v, 8'h00);
        auto_resp = 1'b0;
        exp_q.push_back(0);
        wr(3'd1, 8'h01);
        @(posedge clk);
        #1 man_code = 3'b100; man_tog = ~man_tog;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 3'd3;
        #1 chk(rd_data == 8'h00, "R11 flag before collision", rd_data, 8'h00);
        @(negedge clk);
        rd_en = 1'b0;
        peek(3'd2, v); chk(v == 8'h01, "R11 set wins over clear", v, 8'h01);
        cor(3'd3, v);
        auto_resp = 1'b1;

        // Midspan backoff (R8)
        next_det = 3'b001;
        ds_cyc.delete();
        wr(3'd0, 8'h03);
        exp_q.push_back(0); exp_q.push_back(0);
        w = cyc;
        wr(3'd1, 8'h01);
        for (int i = 0; i < 30_000 && ds_cyc.size() < 2; i++) @(negedge clk);
        chk(ds_cyc.size() == 2, "R8 second detection seen", ds_cyc.size(), 2);
        if (ds_cyc.size() == 2) begin
            chk(ds_cyc[0] - w <= 5, "R8 first detection immediate", ds_cyc[0] - w, 5);
            gap = ds_cyc[1] - ds_cyc[0];
            chk(gap >= BK && gap <= BK + 10, "R8 backoff spacing", gap, BK);
        end
        wr(3'd0, 8'h01);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all expected starts seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule